// File: doc/BRIEF.md
# Windowed Request-Acknowledge Checker

This block watches a request line and an acknowledge line and judges, on every clock edge, the rule that each request is answered by an acknowledge between `MIN_LAG` and `MAX_LAG` cycles later. The window defaults to 1 to 3 cycles. Every edge out of reset opens its own attempt, so back-to-back requests are tracked separately. One acknowledge can close every attempt whose window it falls into.

An edge with the request low closes its attempt at once as a vacuous pass. An attempt that opens with the request high ends in one of two ways. It passes on the first acknowledge inside its window, and the later offsets of that window are then dropped. It fails when its last offset goes by with no acknowledge. The failure is flagged at that last offset, and the cycle index of the request that caused it is given with it, so debug can look back up to `MAX_LAG` cycles. Saturating counters keep the totals of attempts, real passes, vacuous passes and failures. A status flag shows whether the check has ever engaged.

Top module: `rwc_monitor`

## Requirements
- R1: Each rising clock edge with reset released starts one attempt, and `attempts_o` increases by one after that edge.
- R2: An edge with `req` low ends its attempt as a vacuous pass, and `vac_pass_o` increases by one after that edge. An edge with `req` high leaves `vac_pass_o` unchanged.
- R3: An attempt started with `req` high passes at the first edge at an offset of `MIN_LAG` to `MAX_LAG` cycles after its start at which `ack` is high. `real_pass_o` grows by the number of attempts passing at that edge. A later `ack` inside the same window has no further effect on that attempt.
- R4: A single `ack` passes every in-flight attempt whose window contains it. Example with the default window: requests at cycles 0 and 1 and `ack` at cycle 2 add two real passes.
- R5: An attempt whose window ends with no `ack` fails at the edge `MAX_LAG` cycles after its start. `fail_o` is high for the one cycle after that edge, and `fail_cnt_o` increases by one. An `ack` at an offset below `MIN_LAG` (including offset 0) does not satisfy the attempt.
- R6: When `fail_o` rises, `fail_start_o` holds the cycle index of the failing attempt's start. Cycle indices count edges since reset release, and the first such edge is index 0. The value is held until the next failure.
- R7: Every counter stops at 2^`CNT_W`-1 instead of wrapping.
- R8: `engaged_o` is high exactly when `real_pass_o` is nonzero.
- R9: While `rst_n` is low at an edge, all pending attempts are discarded, every counter and `fail_start_o` go to 0, and `fail_o` goes low. Attempts started before the reset never report an outcome.
- R10: While nothing is saturated, `attempts_o` minus the sum of the three outcome counters equals the number of attempts still in flight. That number is never more than `MAX_LAG`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Request line under check |
| ack | input | 1 | Acknowledge line under check |
| fail_o | output | 1 | One-cycle pulse at the end of a failed window |
| fail_start_o | output | STAMP_W | Cycle index at which the last failed attempt started |
| attempts_o | output | CNT_W | Attempts started |
| real_pass_o | output | CNT_W | Non-vacuous passes |
| vac_pass_o | output | CNT_W | Vacuous passes |
| fail_cnt_o | output | CNT_W | Failed attempts |
| engaged_o | output | 1 | At least one real pass has occurred |

## Verification
The bound properties check on every cycle the step of each counter: one attempt per edge, a vacuous pass exactly when the request was low, no real pass without an acknowledge, and no failure on an edge that carried an acknowledge. They also check the balance between attempts, outcomes and in-flight work, saturation holding, and the clean state after reset. The exact cycle of each failure pulse, the captured start index, and how one acknowledge is shared among overlapping windows can only be shown by the scenarios. These are compared against an attempt-by-attempt reference that includes a window ending with no acknowledge and a reset arriving with requests still pending.

// File: rtl/rwc_pkg.sv
// Package rwc_pkg
// Shared helpers for the windowed request-acknowledge checker.
// Assumes 1 <= min_lag <= max_lag.
package rwc_pkg;

    // Default counter and stamp widths used by the top module.
    localparam int DEF_CNT_W   = 32;
    localparam int DEF_STAMP_W = 32;

    // Width needed to hold the number of attempts that can pass at one edge.
    function automatic int hit_width(input int min_lag, input int max_lag);
        int span;
        span = max_lag - min_lag + 1;
        return (span < 2) ? 1 : $clog2(span + 1);
    endfunction

endpackage

// File: rtl/rwc_window.sv
// Module rwc_window
// Keeps the in-flight attempts as a shift register, one bit per age.
// Bit k set: an attempt that started k edges ago is still waiting.
// At each edge it reports how many waiting attempts are answered by ack
// and whether the oldest one expires unanswered.
// Assumes 1 <= MIN_LAG <= MAX_LAG; the outputs hit_cnt and expire are
// combinational from the state and ack.
module rwc_window
    import rwc_pkg::*;
#(
    parameter int MIN_LAG = 1,
    parameter int MAX_LAG = 3,
    parameter int HIT_W   = hit_width(MIN_LAG, MAX_LAG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               ack,
    output logic [MAX_LAG:1]   pend_o,
    output logic [HIT_W-1:0]   hit_cnt,
    output logic               expire
);

    logic [MAX_LAG:1] pend_q;
    logic [MAX_LAG:1] hit;

    // Per-age answer detection: only ages inside the window accept ack.
    for (genvar k = 1; k <= MAX_LAG; k++) begin : g_age
        if (k >= MIN_LAG) begin : g_open
            assign hit[k] = pend_q[k] & ack;
        end else begin : g_early
            assign hit[k] = 1'b0;
        end
    end

    // Age the waiting attempts; answered ones drop out, a new one enters on req.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q[1] <= req;
            for (int k = 2; k <= MAX_LAG; k++) begin
                pend_q[k] <= pend_q[k-1] & ~hit[k-1];
            end
        end
    end

    // Count answered attempts and detect the oldest one running out.
    always_comb begin
        hit_cnt = HIT_W'($countones(hit));
        expire  = pend_q[MAX_LAG] & ~hit[MAX_LAG];
        pend_o  = pend_q;
    end

endmodule

// File: rtl/rwc_sat_cnt.sv
// Module rwc_sat_cnt
// Counter that adds a small increment each cycle and stops at all ones.
// Assumes INC_W <= W.
module rwc_sat_cnt #(
    parameter int W     = 32,
    parameter int INC_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     cnt
);

    localparam logic [W:0] TOP = {1'b0, {W{1'b1}}};

    logic [W:0] sum;

    // Widened sum so that an overflow can be seen before it wraps.
    always_comb begin
        sum = {1'b0, cnt} + {{(W + 1 - INC_W){1'b0}}, inc};
    end

    // Register the sum, clamped to the largest value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (sum > TOP) begin
            cnt <= TOP[W-1:0];
        end else begin
            cnt <= sum[W-1:0];
        end
    end

endmodule

// File: rtl/rwc_stamp.sv
// Module rwc_stamp
// Free-running edge index and capture of the failing attempt's start.
// The attempt that expires at the current edge started exactly MAX_LAG
// edges earlier, so its start index is the current index minus MAX_LAG
// (modulo the stamp width).
module rwc_stamp #(
    parameter int MAX_LAG = 3,
    parameter int STAMP_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               expire,
    output logic [STAMP_W-1:0] start_o
);

    localparam logic [STAMP_W-1:0] LAG = STAMP_W'(MAX_LAG);

    logic [STAMP_W-1:0] cyc_q;

    // Edge index since reset release; the first active edge is index 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // Hold the start index of the most recent failing attempt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o <= '0;
        end else if (expire) begin
            start_o <= cyc_q - LAG;
        end
    end

endmodule

// File: rtl/rwc_monitor.sv
// Module rwc_monitor (top)
// Checks that every request is acknowledged MIN_LAG..MAX_LAG cycles
// later. One attempt opens per edge; each ends as a vacuous pass
// (req low), a real pass (ack inside the window) or a failure (window
// over). It reports a one-cycle failure pulse at the end of the window,
// the start index of the failed attempt, and saturating outcome counters.
// Assumes 1 <= MIN_LAG <= MAX_LAG and synchronous active-low reset.
module rwc_monitor
    import rwc_pkg::*;
#(
    parameter int MIN_LAG = 1,
    parameter int MAX_LAG = 3,
    parameter int CNT_W   = DEF_CNT_W,
    parameter int STAMP_W = DEF_STAMP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               ack,
    output logic               fail_o,
    output logic [STAMP_W-1:0] fail_start_o,
    output logic [CNT_W-1:0]   attempts_o,
    output logic [CNT_W-1:0]   real_pass_o,
    output logic [CNT_W-1:0]   vac_pass_o,
    output logic [CNT_W-1:0]   fail_cnt_o,
    output logic               engaged_o
);

    localparam int HIT_W = hit_width(MIN_LAG, MAX_LAG);

    logic [MAX_LAG:1] pend_w;
    logic [HIT_W-1:0] hit_cnt;
    logic             expire;
    logic             idle_edge;

    rwc_window #(
        .MIN_LAG (MIN_LAG),
        .MAX_LAG (MAX_LAG),
        .HIT_W   (HIT_W)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .ack     (ack),
        .pend_o  (pend_w),
        .hit_cnt (hit_cnt),
        .expire  (expire)
    );

    // A low request closes its attempt at once as a vacuous pass.
    always_comb begin
        idle_edge = ~req;
    end

    rwc_sat_cnt #(.W(CNT_W), .INC_W(1)) u_att (
        .clk (clk), .rst_n (rst_n), .inc (1'b1), .cnt (attempts_o)
    );

    rwc_sat_cnt #(.W(CNT_W), .INC_W(1)) u_vac (
        .clk (clk), .rst_n (rst_n), .inc (idle_edge), .cnt (vac_pass_o)
    );

    rwc_sat_cnt #(.W(CNT_W), .INC_W(HIT_W)) u_pass (
        .clk (clk), .rst_n (rst_n), .inc (hit_cnt), .cnt (real_pass_o)
    );

    rwc_sat_cnt #(.W(CNT_W), .INC_W(1)) u_fail (
        .clk (clk), .rst_n (rst_n), .inc (expire), .cnt (fail_cnt_o)
    );

    rwc_stamp #(.MAX_LAG(MAX_LAG), .STAMP_W(STAMP_W)) u_stamp (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .start_o (fail_start_o)
    );

    // Register the failure pulse so that it lines up with the counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_o <= 1'b0;
        end else begin
            fail_o <= expire;
        end
    end

    // Engaged once any real pass has been recorded.
    always_comb begin
        engaged_o = |real_pass_o;
    end

endmodule

// File: rtl/rwc_props.sv
// Module rwc_props
// Property checker bound to rwc_monitor. It watches the ports and the
// in-flight vector. It drives nothing.
module rwc_props #(
    parameter int MIN_LAG = 1,
    parameter int MAX_LAG = 3,
    parameter int CNT_W   = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req,
    input logic               ack,
    input logic               fail_o,
    input logic [CNT_W-1:0]   attempts_o,
    input logic [CNT_W-1:0]   real_pass_o,
    input logic [CNT_W-1:0]   vac_pass_o,
    input logic [CNT_W-1:0]   fail_cnt_o,
    input logic               engaged_o,
    input logic [MAX_LAG:1]   pend
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [CNT_W+1:0] outcome_sum;
    logic [CNT_W+1:0] inflight;

    // Totals for the balance check, widened so the sum cannot wrap.
    always_comb begin
        outcome_sum = (CNT_W+2)'(vac_pass_o) + (CNT_W+2)'(real_pass_o)
                    + (CNT_W+2)'(fail_cnt_o);
        inflight    = (CNT_W+2)'($countones(pend));
    end

    // R1: one attempt per active edge.
    p_attempt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(attempts_o) != TOP) |-> attempts_o == $past(attempts_o) + 1'b1);

    // R2: a low request adds one vacuous pass.
    p_vac_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(req) && $past(vac_pass_o) != TOP) |-> vac_pass_o == $past(vac_pass_o) + 1'b1);

    // R2: a high request leaves the vacuous count alone.
    p_vac_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req)) |-> $stable(vac_pass_o));

    // R3: no real pass without an acknowledge.
    p_no_ack_no_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ack)) |-> $stable(real_pass_o));

    // R5: a window cannot run out on an edge that carried ack.
    p_fail_no_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> !$past(ack));

    // R5: each failure pulse adds one to the failure count.
    p_fail_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && fail_o && $past(fail_cnt_o) != TOP) |-> fail_cnt_o == $past(fail_cnt_o) + 1'b1);

    // R7: a saturated counter stays saturated.
    p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(attempts_o) == TOP) |-> attempts_o == TOP);

    // R8: engagement never drops while out of reset.
    p_engaged_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(engaged_o)) |-> engaged_o);

    // R9: the first cycle after reset shows a clean state.
    p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (attempts_o == '0 && fail_cnt_o == '0 && !fail_o));

    // R10: attempts balance outcomes plus in-flight work.
    p_balance_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (attempts_o != TOP) |-> (CNT_W+2)'(attempts_o) == outcome_sum + inflight);

endmodule

bind rwc_monitor rwc_props #(
    .MIN_LAG (MIN_LAG),
    .MAX_LAG (MAX_LAG),
    .CNT_W   (CNT_W)
) u_props (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .ack         (ack),
    .fail_o      (fail_o),
    .attempts_o  (attempts_o),
    .real_pass_o (real_pass_o),
    .vac_pass_o  (vac_pass_o),
    .fail_cnt_o  (fail_cnt_o),
    .engaged_o   (engaged_o),
    .pend        (pend_w)
);

// File: tb/sim_rwc_monitor.sv
`timescale 1ns/1ps
// Bench sim_rwc_monitor: the driver updates an attempt-by-attempt
// reference and queues the expected outputs. The monitor pops them
// after each edge and compares. u1 has 3-bit counters for saturation.
module sim_rwc_monitor;

    localparam int MINL = 1;
    localparam int MAXL = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic ack = 1'b0;

    logic        fail0, eng0;
    logic [31:0] st0, att0, pas0, vac0, fl0;
    logic        fail1, eng1;
    logic [31:0] st1;
    logic [2:0]  att1, pas1, vac1, fl1;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    rwc_monitor u0 (
        .clk (clk), .rst_n (rst_n), .req (req), .ack (ack),
        .fail_o (fail0), .fail_start_o (st0), .attempts_o (att0),
        .real_pass_o (pas0), .vac_pass_o (vac0), .fail_cnt_o (fl0),
        .engaged_o (eng0)
    );

    rwc_monitor #(.CNT_W(3)) u1 (
        .clk (clk), .rst_n (rst_n), .req (req), .ack (ack),
        .fail_o (fail1), .fail_start_o (st1), .attempts_o (att1),
        .real_pass_o (pas1), .vac_pass_o (vac1), .fail_cnt_o (fl1),
        .engaged_o (eng1)
    );

    typedef struct {
        bit     failp;
        longint stamp;
        longint att;
        longint vac;
        longint pas;
        longint fl;
        longint pend;
    } exp_t;

    exp_t   sb[$];
    int     open_q[$];
    int     cyc;
    exp_t   m;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint sat3(input longint v);
        return (v > 7) ? 7 : v;
    endfunction

    task automatic model_clear();
        open_q.delete();
        cyc     = 0;
        m       = '{default: 0};
        sb.delete();
    endtask

    // Driver: called at a negedge; drives one edge and queues its expectation.
    task automatic step(input bit r, input bit a);
        int keep[$];
        int np;
        req = r;
        ack = a;
        np = 0;
        m.failp = 1'b0;
        foreach (open_q[i]) begin
            int age;
            age = cyc - open_q[i];
            if (a && age >= MINL) begin
                np++;
            end else if (age >= MAXL) begin
                m.failp = 1'b1;
                m.stamp = open_q[i];
            end else begin
                keep.push_back(open_q[i]);
            end
        end
        if (r) keep.push_back(cyc);
        else   m.vac++;
        open_q = keep;
        m.att++;
        m.pas += np;
        if (m.failp) m.fl++;
        m.pend = open_q.size();
        cyc++;
        sb.push_back(m);
        @(negedge clk);
    endtask

    // Monitor: compare queued expectations 5 ns after each edge.
    always @(posedge clk) begin
        #5;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk("R1 attempts",     att0, e.att);
            chk("R2 vacuous",      vac0, e.vac);
            chk("R3 real pass",    pas0, e.pas);
            chk("R5 fail pulse",   fail0, e.failp);
            chk("R5 fail count",   fl0, e.fl);
            chk("R6 fail start",   st0, e.stamp);
            chk("R8 engaged",      eng0, (e.pas != 0));
            chk("R10 in flight",   longint'(att0) - vac0 - pas0 - fl0, e.pend);
            chk("R7 sat attempts", att1, sat3(e.att));
            chk("R7 sat vacuous",  vac1, sat3(e.vac));
            chk("R7 sat pass",     pas1, sat3(e.pas));
            chk("R7 sat fail",     fl1, sat3(e.fl));
        end
    end

    // Reset for two edges and confirm the cleared state (R9).
    task automatic do_reset();
        rst_n = 1'b0;
        req   = 1'b0;
        ack   = 1'b0;
        model_clear();
        repeat (2) @(negedge clk);
        chk("R9 reset attempts", att0, 0);
        chk("R9 reset pass",     pas0, 0);
        chk("R9 reset fail",     fail0, 0);
        chk("R9 reset stamp",    st0, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        longint p0;
        longint f0;
        int     lcg;
        @(negedge clk);
        do_reset();

        // Idle edges: vacuous passes only.
        repeat (3) step(0, 0);
        // Ack at offset 1.
        step(1, 0); step(0, 1);
        // Ack at offset 3, the last chance.
        step(1, 0); step(0, 0); step(0, 0); step(0, 1);
        // No ack: failure at offset 3.
        step(1, 0); repeat (4) step(0, 0);
        // Ack only at offset 0 does not count (R5).
        step(1, 1); repeat (4) step(0, 0);
        // Second ack after a pass is ignored (R3).
        step(1, 0); step(0, 1); step(0, 1); repeat (3) step(0, 0);
        chk("R3 no fail after late ack", fail0, 0);

        // One ack shared by two overlapping attempts (R4).
        p0 = pas0;
        f0 = fl0;
        step(1, 0); step(1, 0); step(0, 1);
        chk("R4 shared ack passes", longint'(pas0) - p0, 2);
        repeat (4) step(0, 0);
        chk("R4 no failure", longint'(fl0) - f0, 0);

        // Mid-run reset with attempts pending (R9).
        step(1, 0); step(1, 0);
        do_reset();
        repeat (5) step(0, 0);
        chk("R9 no stale fail count", fl0, 0);

        // Mixed traffic from a fixed pseudo-random sequence.
        lcg = 12345;
        for (int i = 0; i < 400; i++) begin
            lcg = lcg * 1103515245 + 12345;
            step(lcg[16], (lcg[20:19] == 2'b00));
        end
        repeat (4) step(0, 0);
        chk("R7 narrow attempts saturated", att1, 7);

        @(posedge clk);
        #6;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #4000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule